// File: doc/BRIEF.md
# Oversampled SPI Mode-0 Target

This block is an SPI target (slave) that lives entirely in a fast system clock domain. The serial clock, select and data-in lines from the controller are treated as asynchronous. Each is passed through a chain of synchronizer flip-flops. Transitions of the serial clock are turned into one-cycle rise and fall strobes. The serial clock never clocks any flip-flop in the block.

Only mode 0 is handled: the serial clock idles low, and the controller samples on rising edges. The block captures incoming data on every rise strobe. It advances its outgoing shift register on every fall strobe. A transmit word is taken from `tx_data` when the synchronized select becomes active, and again after every completed word, so words can follow each other inside one frame. Each completed received word appears on `rx_data` together with a one-cycle `rx_valid` pulse.

The strobes lag the real serial clock edges by a few system clocks. For this reason the serial clock must be slow compared with the system clock. Each serial clock phase has to last at least four system clocks. That gives the outgoing bit time to settle before the controller samples it.

Top module: `spi_os_target`

## Requirements
- R1: During and after reset, with select inactive, `miso` = 0, `miso_oe` = 0, `rx_valid` = 0 and `rx_data` = 0.
- R2: A low-to-high change of `sck` that is set up before system clock edge 1 gives `sck_rise` high for exactly one cycle, after edge 3. A high-to-low change gives `sck_fall` in the same way. The two strobes are never high together.
- R3: Incoming `mosi` bits are taken most significant first, one per rise strobe. After the DATA_W-th rise strobe of a word, `rx_data` holds that word and `rx_valid` is high for exactly one cycle.
- R4: When the synchronized `ss_n` goes low, `tx_data` is loaded. `miso_oe` goes high, and `miso` shows bit DATA_W-1 of the loaded word before the first rising `sck`.
- R5: Each fall strobe moves `miso` to the next lower bit of the word. The fall strobe that follows the last bit of a word reloads from `tx_data`, so back-to-back words within one frame are sent correctly.
- R6: While the synchronized `ss_n` is high, `sck` and `mosi` activity is ignored and no `rx_valid` is produced. `miso` and `miso_oe` are 0. A frame cut off mid-word is discarded, and the next frame starts again at bit DATA_W-1.
- R7: `rx_data` keeps the last complete word until the next word completes, including across an aborted frame.
- R8: The transfer is correct for any `sck` phase length of four or more system clocks, with `ss_n` changes also spaced four or more system clocks from the nearest `sck` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the controller, asynchronous |
| ss_n | input | 1 | Target select, active low, asynchronous |
| mosi | input | 1 | Serial data from the controller, asynchronous |
| tx_data | input | DATA_W | Word to transmit, sampled at select and at each word boundary |
| miso | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | High while this target drives `miso` |
| rx_data | output | DATA_W | Last completely received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| sck_rise | output | 1 | One-cycle strobe for a rising serial clock |
| sck_fall | output | 1 | One-cycle strobe for a falling serial clock |

## Verification
If the bit counter or the reload flag is wrong, the fault shows up within one word. The `rx_valid` pulse arrives after the wrong number of rise strobes, or the controller model samples the wrong bit on its next rising `sck`. A synchronizer chain of the wrong depth moves `sck_rise` and `sck_fall` off the third system edge, which is visible at once. If the select-framing state is stale, it shows at the first rising `sck` of the next frame, as a wrong first `miso` bit, or as a word built from leftover bits of an aborted frame.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    // Registered edge-detector state: the delayed serial-clock sample and
    // the two one-cycle strobes derived from it.
    typedef struct packed {
        logic older;
        logic rise;
        logic fall;
    } strobe_state_t;

endpackage

// File: rtl/spi_os_sync.sv
// Multi-bit synchronizer: each input bit runs through its own chain of
// STAGES flip-flops. Stage 0 takes the raw input.
module spi_os_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign dout[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_os_edge.sv
// Edge detector for a synchronized level. It holds one more delayed copy
// of the level and registers rise and fall strobes, each one cycle wide.
module spi_os_edge
    import spi_os_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic newer,
    output logic rise,
    output logic fall
);

    strobe_state_t st_d;
    strobe_state_t st_q;

    always_comb begin
        st_d.older = newer;
        st_d.rise  = newer & ~st_q.older;
        st_d.fall  = st_q.older & ~newer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.rise;
    assign fall = st_q.fall;

endmodule

// File: rtl/spi_os_core.sv
// Framing and shifting engine driven by the synchronized select, the
// synchronized data-in bit and the serial clock strobes.
module spi_os_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    input  logic              rise,
    input  logic              fall,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

    typedef struct packed {
        logic              ss_prev;
        logic [CW-1:0]     bit_cnt;
        logic              reload;
        logic [DATA_W-2:0] rx_sh;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_word;
        logic              rx_pulse;
    } core_state_t;

    core_state_t cs_d;
    core_state_t cs_q;

    always_comb begin
        cs_d          = cs_q;
        cs_d.rx_pulse = 1'b0;
        cs_d.ss_prev  = ss_n_s;

        if (ss_n_s) begin
            // Deselected: drop any partial word.
            cs_d.bit_cnt = '0;
            cs_d.reload  = 1'b0;
            cs_d.rx_sh   = '0;
            cs_d.tx_sh   = '0;
        end else if (cs_q.ss_prev) begin
            // Select just became active: present the first word.
            cs_d.bit_cnt = '0;
            cs_d.reload  = 1'b0;
            cs_d.rx_sh   = '0;
            cs_d.tx_sh   = tx_data;
        end else begin
            if (rise) begin
                cs_d.rx_sh = {cs_q.rx_sh[DATA_W-3:0], mosi_s};
                if (cs_q.bit_cnt == LAST_BIT) begin
                    cs_d.bit_cnt  = '0;
                    cs_d.rx_word  = {cs_q.rx_sh, mosi_s};
                    cs_d.rx_pulse = 1'b1;
                    cs_d.reload   = 1'b1;
                end else begin
                    cs_d.bit_cnt = cs_q.bit_cnt + 1'b1;
                end
            end
            if (fall) begin
                if (cs_q.reload) begin
                    cs_d.tx_sh  = tx_data;
                    cs_d.reload = 1'b0;
                end else begin
                    cs_d.tx_sh = {cs_q.tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q         <= '0;
            cs_q.ss_prev <= 1'b1;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign miso_oe  = ~cs_q.ss_prev;
    assign miso     = ~cs_q.ss_prev & cs_q.tx_sh[DATA_W-1];
    assign rx_data  = cs_q.rx_word;
    assign rx_valid = cs_q.rx_pulse;

endmodule

// File: rtl/spi_os_target.sv
// SPI mode-0 target working only in the system clock domain.
module spi_os_target #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              ss_n,
    input  logic              mosi,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sck_rise,
    output logic              sck_fall
);

    // The edge detector adds the last stage for the serial clock, so its
    // chain is one shorter; all three lines then see the same delay.
    localparam int SCK_CHAIN = SYNC_STAGES - 1;

    logic       sck_s;
    logic [1:0] ctl_s;
    logic       ss_n_s;
    logic       mosi_s;

    spi_os_sync #(
        .W       (1),
        .STAGES  (SCK_CHAIN),
        .RST_VAL (1'b0)
    ) u_sync_sck (
        .clk  (clk),
        .rst  (rst),
        .din  (sck),
        .dout (sck_s)
    );

    spi_os_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync_ctl (
        .clk  (clk),
        .rst  (rst),
        .din  ({mosi, ss_n}),
        .dout (ctl_s)
    );

    assign ss_n_s = ctl_s[0];
    assign mosi_s = ctl_s[1];

    spi_os_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .newer (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    spi_os_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .ss_n_s   (ss_n_s),
        .mosi_s   (mosi_s),
        .rise     (sck_rise),
        .fall     (sck_fall),
        .tx_data  (tx_data),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/spi_os_target_chk.sv
module spi_os_target_chk #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst,
    input logic ss_n_s,
    input logic sck_rise,
    input logic sck_fall,
    input logic miso,
    input logic miso_oe,
    input logic rx_valid
);

    // Rise strobes counted since the select became active.
    logic [15:0] rise_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ss_n_s) begin
            rise_cnt_q <= '0;
        end else if (sck_rise) begin
            rise_cnt_q <= rise_cnt_q + 16'd1;
        end
    end

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(sck_rise && sck_fall));

    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> !sck_rise);

    assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst)
        sck_fall |=> !sck_fall);

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_valid_follows_rise_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(sck_rise));

    assert_valid_word_count_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rise_cnt_q != 16'd0 && (rise_cnt_q % 16'(DATA_W)) == 16'd0));

    assert_idle_miso_R6: assert property (@(posedge clk) disable iff (rst)
        $past(ss_n_s) |-> (!miso && !miso_oe));

    assert_no_valid_deselected_R6: assert property (@(posedge clk) disable iff (rst)
        $past(ss_n_s) |-> !rx_valid);

endmodule

bind spi_os_target spi_os_target_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ss_n_s   (ss_n_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .rx_valid (rx_valid)
);

// File: tb/spi_os_target_test.sv
`timescale 1ns/1ps
module spi_os_target_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sck = 1'b0;
    logic          ss_n = 1'b1;
    logic          mosi = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          miso;
    logic          miso_oe;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          sck_rise;
    logic          sck_fall;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] got [16];
    int n_got     = 0;
    int dbl_valid = 0;
    logic prev_valid = 1'b0;

    always #2 clk = ~clk;

    spi_os_target #(.DATA_W(DW), .SYNC_STAGES(3)) uut (
        .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi),
        .tx_data(tx_data), .miso(miso), .miso_oe(miso_oe),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    // Record received words, sampled one ns after each edge.
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (rx_valid) begin
                if (n_got < 16) got[n_got] = rx_data;
                n_got++;
            end
            if (rx_valid && prev_valid) dbl_valid++;
            prev_valid = rx_valid;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Controller model: mode 0, samples miso just before each rising sck.
    // Words are packed from bit 31 downwards. cut < nbytes*8 aborts early.
    task automatic run_frame(input int half, input int nbytes,
                             input logic [31:0] txw, input logic [31:0] mow,
                             input int cut, output int miso_err,
                             output bit first_ok);
        int total = nbytes * DW;
        if (cut < total) total = cut;
        miso_err = 0;
        first_ok = 1'b0;
        tx_data = txw[31 -: DW];
        ss_n = 1'b0;
        for (int b = 0; b < total; b++) begin
            mosi = mow[31-b];
            wait_cyc(half);
            if (b == 0) first_ok = (miso === txw[31]) && (miso_oe === 1'b1);
            else if (miso !== txw[31-b] || miso_oe !== 1'b1) miso_err++;
            sck = 1'b1;
            if ((b % DW) == 0 && (b / DW) + 1 < nbytes)
                tx_data = txw[31 - DW*((b / DW) + 1) -: DW];
            wait_cyc(half);
            sck = 1'b0;
        end
        wait_cyc(half);
        ss_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        chk(miso === 1'b0 && miso_oe === 1'b0, "R1", "miso/oe in reset", {miso, miso_oe}, 0);
        chk(rx_valid === 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        wait_cyc(1);
        rst = 1'b0;
        wait_cyc(3);
        chk(rx_data === '0 && rx_valid === 1'b0, "R1", "rx after reset", rx_data, 0);
        chk(miso === 1'b0 && miso_oe === 1'b0, "R1", "miso/oe after reset", {miso, miso_oe}, 0);
    endtask

    task automatic t_strobes();
        int base = n_got;
        logic [2:0] seen;
        sck = 1'b1;
        @(posedge clk); #1; seen[0] = sck_rise;
        @(posedge clk); #1; seen[1] = sck_rise;
        @(posedge clk); #1; seen[2] = sck_rise;
        @(posedge clk); #1;
        chk(seen == 3'b100 && sck_rise === 1'b0 && sck_fall === 1'b0,
            "R2", "rise strobe timing", {seen, sck_rise}, 4'b1000);
        @(negedge clk);
        sck = 1'b0;
        @(posedge clk); #1; seen[0] = sck_fall;
        @(posedge clk); #1; seen[1] = sck_fall;
        @(posedge clk); #1; seen[2] = sck_fall;
        @(posedge clk); #1;
        chk(seen == 3'b100 && sck_fall === 1'b0 && sck_rise === 1'b0,
            "R2", "fall strobe timing", {seen, sck_fall}, 4'b1000);
        // Full burst of sck/mosi while deselected: must be ignored.
        @(negedge clk);
        for (int i = 0; i < DW; i++) begin
            mosi = i[0];
            sck = 1'b1; wait_cyc(4);
            sck = 1'b0; wait_cyc(4);
        end
        chk(n_got == base, "R6", "rx_valid while deselected", n_got - base, 0);
        chk(miso === 1'b0 && miso_oe === 1'b0, "R6", "miso while deselected", {miso, miso_oe}, 0);
    endtask

    task automatic t_single(input int half, input logic [7:0] txb, input logic [7:0] mob);
        int base = n_got;
        int err;
        bit f_ok;
        run_frame(half, 1, {txb, 24'h0}, {mob, 24'h0}, DW, err, f_ok);
        chk(f_ok, "R4", "first miso bit and oe", {31'h0, f_ok}, 1);
        chk(err == 0, "R5", "miso bit errors", err, 0);
        chk(n_got == base + 1 && got[base] === mob, "R3", "received word",
            got[base], mob);
        chk(dbl_valid == 0, "R3", "rx_valid width", dbl_valid, 0);
    endtask

    task automatic t_burst(input int half);
        int base = n_got;
        int err;
        bit f_ok;
        run_frame(half, 3, 32'hA5_3C_F0_00, 32'h12_EF_80_00, 3*DW, err, f_ok);
        chk(f_ok, "R4", "burst first bit", {31'h0, f_ok}, 1);
        chk(err == 0, "R5", "back-to-back miso errors", err, 0);
        chk(n_got == base + 3, "R3", "burst word count", n_got - base, 3);
        chk(got[base] === 8'h12 && got[base+1] === 8'hEF && got[base+2] === 8'h80,
            "R3", "burst words", {got[base], got[base+1], got[base+2]}, 24'h12EF80);
        chk(rx_data === 8'h80, "R7", "rx_data holds after frame", rx_data, 8'h80);
    endtask

    task automatic t_abort();
        int base = n_got;
        int err;
        bit f_ok;
        logic [DW-1:0] held = rx_data;
        run_frame(4, 1, {8'hC3, 24'h0}, {8'hFF, 24'h0}, 5, err, f_ok);
        chk(n_got == base, "R6", "aborted word dropped", n_got - base, 0);
        chk(rx_data === held, "R7", "rx_data after abort", rx_data, held);
        chk(miso === 1'b0 && miso_oe === 1'b0, "R6", "miso after abort", {miso, miso_oe}, 0);
        run_frame(4, 1, {8'h5A, 24'h0}, {8'h81, 24'h0}, DW, err, f_ok);
        chk(f_ok && err == 0, "R6", "fresh tx after abort", err, 0);
        chk(n_got == base + 1 && got[base] === 8'h81, "R6", "fresh rx after abort",
            got[base], 8'h81);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(4);
        t_reset();
        t_strobes();
        t_single(4, 8'hA5, 8'h3C);   // R8: shortest allowed phase
        t_single(10, 8'h69, 8'hD2);  // R8: slower sck
        t_single(4, 8'h00, 8'hFF);
        t_burst(4);
        t_burst(7);
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule